// File: doc/BRIEF.md
# Gain-State Decoder and Pixel Packer

This block sits in the digital path of an imaging detector read-out, after the converters have been deserialized. Each pixel in each image delivers two 14-bit samples: one measuring the integrated signal and one measuring the level of the gain-switch node in the pixel amplifier. The block turns the gain-level sample into a 2-bit gain code by testing it against four programmable thresholds. It then joins that code with the signal sample into one 16-bit word.

The four thresholds describe three acceptance windows, one for each gain setting of the amplifier. A gain-level sample that falls in none of the windows cannot be classified with confidence. It receives the spare fourth code, so that later processing can pick it out for debug. A saturating tally counts the uncertain words that have been emitted. A clear input resets the tally.

A word is produced only for a complete pair, meaning both samples are flagged valid in the same cycle. The word appears at a fixed latency of two clock edges.

Top module: `gain_code_packer`

## Requirements
- R1: Every emitted word carries the analog sample in bits 13:0 and the gain code in bits 15:14.
- R2: A gain sample less than or equal to `lim_high_top` gets code 00 (high gain). This test has the highest priority.
- R3: A sample that is not high gain and lies within `lim_mid_bot` to `lim_mid_top`, both ends included, gets code 01 (medium gain). This test has priority over the low-gain test.
- R4: A sample that is neither high nor medium gain, and is greater than or equal to `lim_low_bot`, gets code 10 (low gain).
- R5: A sample that matches none of the three windows gets code 11 (uncertain).
- R6: A word is produced only when `ana_vld` and `gsm_vld` are both high in the same cycle. A sample that arrives alone is dropped, and `word_vld` stays low for it.
- R7: The inputs and thresholds captured at clock edge N appear at the output after edge N+1, with `word_vld` high.
- R8: `tally` grows by one for each emitted word whose code is 11. It saturates at its all-ones value.
- R9: When `tally_clr` is high at an edge, `tally` becomes 0 after that edge. The clear takes priority over an increment at the same edge.
- R10: While `rst_n` is low, `word_vld`, `word_out` and `tally` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ana_vld | input | 1 | Analog sample valid |
| ana_data | input | SAMPLE_W | Analog sample |
| gsm_vld | input | 1 | Gain-level sample valid |
| gsm_data | input | SAMPLE_W | Gain-level sample |
| lim_high_top | input | SAMPLE_W | Upper bound of the high-gain window |
| lim_mid_bot | input | SAMPLE_W | Lower bound of the medium-gain window |
| lim_mid_top | input | SAMPLE_W | Upper bound of the medium-gain window |
| lim_low_bot | input | SAMPLE_W | Lower bound of the low-gain window |
| tally_clr | input | 1 | Clears the uncertain-word tally |
| word_vld | output | 1 | Output word valid |
| word_out | output | SAMPLE_W+2 | Packed word: gain code in the top two bits, analog sample below |
| tally | output | CNT_W | Saturating count of uncertain words |

## Verification
The latency and pairing properties assume that `rst_n` stays high for at least two edges after any pair is presented. They also assume that the thresholds are sampled together with the gain sample, with no separate setup phase. The bench meets both conditions: it releases reset once and never asserts it again, and it drives a fresh set of thresholds together with every pair.

The classification checks require no particular ordering of the thresholds. Random threshold sets are sometimes sorted and sometimes left unsorted, so the priority rules are exercised on overlapping windows as well as on disjoint ones. Gain samples are drawn close to the threshold values so that the window boundaries are hit often.

// File: rtl/gain_code_packer.sv
module gain_code_packer #(
  parameter int SAMPLE_W = 14,
  parameter int CNT_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ana_vld,
  input  logic [SAMPLE_W-1:0]   ana_data,
  input  logic                  gsm_vld,
  input  logic [SAMPLE_W-1:0]   gsm_data,
  input  logic [SAMPLE_W-1:0]   lim_high_top,
  input  logic [SAMPLE_W-1:0]   lim_mid_bot,
  input  logic [SAMPLE_W-1:0]   lim_mid_top,
  input  logic [SAMPLE_W-1:0]   lim_low_bot,
  input  logic                  tally_clr,
  output logic                  word_vld,
  output logic [SAMPLE_W+1:0]   word_out,
  output logic [CNT_W-1:0]      tally
);

  localparam logic [1:0] CODE_HIGH = 2'b00;
  localparam logic [1:0] CODE_MID  = 2'b01;
  localparam logic [1:0] CODE_LOW  = 2'b10;
  localparam logic [1:0] CODE_UNC  = 2'b11;
  localparam logic [CNT_W-1:0] TALLY_MAX = '1;

  logic                pair_ok;
  logic                in_high, in_mid, in_low;
  logic [1:0]          code_c;
  logic                s1_vld;
  logic [1:0]          s1_code;
  logic [SAMPLE_W-1:0] s1_ana;

  assign pair_ok = ana_vld & gsm_vld;
  assign in_high = gsm_data <= lim_high_top;
  assign in_mid  = (gsm_data >= lim_mid_bot) && (gsm_data <= lim_mid_top);
  assign in_low  = gsm_data >= lim_low_bot;

  always_comb begin
    if (in_high)     code_c = CODE_HIGH;
    else if (in_mid) code_c = CODE_MID;
    else if (in_low) code_c = CODE_LOW;
    else             code_c = CODE_UNC;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_code <= CODE_HIGH;
      s1_ana  <= '0;
    end else begin
      s1_vld <= pair_ok;
      if (pair_ok) begin
        s1_code <= code_c;
        s1_ana  <= ana_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_vld <= 1'b0;
      word_out <= '0;
    end else begin
      word_vld <= s1_vld;
      if (s1_vld) word_out <= {s1_code, s1_ana};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      tally <= '0;
    else if (tally_clr)
      tally <= '0;
    else if (s1_vld && s1_code == CODE_UNC && tally != TALLY_MAX)
      tally <= tally + 1'b1;
  end

endmodule

module gain_code_packer_chk #(
  parameter int SAMPLE_W = 14,
  parameter int CNT_W    = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ana_vld,
  input logic                gsm_vld,
  input logic [SAMPLE_W-1:0] ana_data,
  input logic                word_vld,
  input logic [SAMPLE_W-1:0] word_ana,
  input logic                tally_clr,
  input logic [CNT_W-1:0]    tally
);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ana_vld && gsm_vld) |-> ##2 word_vld);

  assert_no_orphan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(ana_vld && gsm_vld, 2));

  assert_analog_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> word_ana == $past(ana_data, 2));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tally_clr |=> tally == '0);

  assert_no_decrease_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tally_clr |=> tally >= $past(tally));

endmodule

bind gain_code_packer gain_code_packer_chk #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ana_vld(ana_vld), .gsm_vld(gsm_vld),
  .ana_data(ana_data), .word_vld(word_vld), .word_ana(word_out[SAMPLE_W-1:0]),
  .tally_clr(tally_clr), .tally(tally)
);

// File: tb/gain_code_packer_bench.sv
module gain_code_packer_bench;
  localparam int SW = 14;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ana_vld = 1'b0, gsm_vld = 1'b0, tally_clr = 1'b0;
  logic [SW-1:0] ana_data = '0, gsm_data = '0;
  logic [SW-1:0] t0 = '0, t1 = '0, t2 = '0, t3 = '0;
  logic word_vld;
  logic [SW+1:0] word_out;
  logic [CW-1:0] tally;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic p1v = 0, p2v = 0;
  logic [SW+1:0] p1w = '0, p2w = '0;
  logic prev_clr = 0;
  logic [CW-1:0] exp_tally = '0;

  always #10 clk = ~clk;

  gain_code_packer #(.SAMPLE_W(SW), .CNT_W(CW)) u_gain_code_packer (
    .clk(clk), .rst_n(rst_n), .ana_vld(ana_vld), .ana_data(ana_data),
    .gsm_vld(gsm_vld), .gsm_data(gsm_data), .lim_high_top(t0),
    .lim_mid_bot(t1), .lim_mid_top(t2), .lim_low_bot(t3),
    .tally_clr(tally_clr), .word_vld(word_vld), .word_out(word_out), .tally(tally));

  function automatic logic [1:0] classify(input logic [SW-1:0] g, a0, a1, a2, a3);
    if (g <= a0) return 2'b00;
    if (g >= a1 && g <= a2) return 2'b01;
    if (g >= a3) return 2'b10;
    return 2'b11;
  endfunction

  function automatic string req_of(input logic [1:0] c);
    case (c)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic av, input logic gv, input logic [SW-1:0] a,
                      input logic [SW-1:0] g, input logic [SW-1:0] h0,
                      input logic [SW-1:0] h1, input logic [SW-1:0] h2,
                      input logic [SW-1:0] h3, input logic clr);
    @(negedge clk);
    if (prev_clr) exp_tally = '0;
    else if (p2v && p2w[SW+1:SW] == 2'b11 && exp_tally != '1) exp_tally = exp_tally + 1'b1;
    chk("R6_R7 word_vld", longint'(word_vld), longint'(p2v));
    if (p2v) begin
      chk("R1 analog field", longint'(word_out[SW-1:0]), longint'(p2w[SW-1:0]));
      chk(req_of(p2w[SW+1:SW]), longint'(word_out[SW+1:SW]), longint'(p2w[SW+1:SW]));
    end
    chk("R8_R9 tally", longint'(tally), longint'(exp_tally));
    p2v = p1v; p2w = p1w;
    p1v = av & gv;
    p1w = {classify(g, h0, h1, h2, h3), a};
    prev_clr = clr;
    ana_vld = av; gsm_vld = gv; ana_data = a; gsm_data = g;
    t0 = h0; t1 = h1; t2 = h2; t3 = h3; tally_clr = clr;
  endtask

  task automatic pix(input logic [SW-1:0] a, input logic [SW-1:0] g);
    step(1, 1, a, g, 14'd100, 14'd200, 14'd300, 14'd400, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    ana_vld = 1; gsm_vld = 1; ana_data = 14'h1abc; gsm_data = 14'h3fff;
    repeat (3) begin
      @(negedge clk);
      chk("R10 reset word_vld", longint'(word_vld), 0);
      chk("R10 reset word_out", longint'(word_out), 0);
      chk("R10 reset tally", longint'(tally), 0);
    end
    ana_vld = 0; gsm_vld = 0;
    rst_n = 1;
    // window edges (R2 R3 R4 R5)
    pix(14'h0001, 14'd0);
    pix(14'h0002, 14'd100);
    pix(14'h0003, 14'd101);
    pix(14'h0004, 14'd199);
    pix(14'h0005, 14'd200);
    pix(14'h0006, 14'd300);
    pix(14'h0007, 14'd301);
    pix(14'h0008, 14'd399);
    pix(14'h0009, 14'd400);
    pix(14'h3fff, 14'h3fff);
    // overlapping windows: priority (R2 over R3, R3 over R4)
    step(1, 1, 14'h0aaa, 14'd250, 14'd300, 14'd200, 14'd400, 14'd100, 0);
    step(1, 1, 14'h0bbb, 14'd350, 14'd10, 14'd200, 14'd400, 14'd100, 0);
    // lone samples dropped (R6)
    step(1, 0, 14'h1111, 14'd0, 14'd100, 14'd200, 14'd300, 14'd400, 0);
    step(0, 1, 14'h2222, 14'd0, 14'd100, 14'd200, 14'd300, 14'd400, 0);
    step(0, 0, 14'h0, 14'd0, 14'd100, 14'd200, 14'd300, 14'd400, 0);
    // clear together with an uncertain word (R9)
    pix(14'h0c0c, 14'd150);
    step(0, 0, 14'h0, 14'd0, 14'd100, 14'd200, 14'd300, 14'd400, 1);
    step(0, 0, 14'h0, 14'd0, 14'd100, 14'd200, 14'd300, 14'd400, 0);
    // saturation (R8)
    for (int i = 0; i < 20; i++) pix(14'(i), 14'd350);
    step(0, 0, 14'h0, 14'd0, 14'd100, 14'd200, 14'd300, 14'd400, 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [SW-1:0] h [4];
      logic [SW-1:0] g;
      int pick;
      for (int k = 0; k < 4; k++) h[k] = 14'($urandom_range(0, 16383));
      if ($urandom_range(0, 3) != 0) begin
        for (int a = 0; a < 3; a++)
          for (int b = 0; b < 3 - a; b++)
            if (h[b] > h[b+1]) begin
              logic [SW-1:0] tmp;
              tmp = h[b]; h[b] = h[b+1]; h[b+1] = tmp;
            end
      end
      pick = $urandom_range(0, 4);
      if (pick == 4) g = 14'($urandom_range(0, 16383));
      else g = h[pick] + 14'($urandom_range(0, 4)) - 14'd2;
      step($urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0,
           14'($urandom_range(0, 16383)), g, h[0], h[1], h[2], h[3],
           $urandom_range(0, 60) == 0);
    end
    repeat (3) step(0, 0, 14'h0, 14'h0, 14'h0, 14'h0, 14'h0, 14'h0, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule